// File: doc/BRIEF.md
# Hypervisor-Aware Periodic Tick Timer

This block is the operating-system tick timer of a core that runs guests under a hardware-assisted hypervisor. It holds two counters. The guest counter is an ordinary periodic interval timer with a programmable period and a sticky status flag. The hypervisor counter is visible only while the core is in hypervisor mode. It drives a scheduling-tick interrupt line that goes straight to the core and does not pass through the interrupt controller.

The two counters are coupled in two ways. While the core runs in hypervisor mode, the guest counter is frozen. When the hypervisor restores a guest's counter by writing it, the block adds the hypervisor counter's current value to the written value. The guest therefore sees the time it spent descheduled. If that sum reaches the guest period, the guest interrupt is raised at once, and the counter keeps the excess so that the tick phase is not lost.

Both counters advance on a shared prescaled tick enable. Registers are accessed through a simple select/data port. Reads are combinational, and writes take effect at the clock edge.

Top module: `hvTickTimer`

## Requirements
- R1: After reset, every register (guest period, guest count, status, hypervisor count, hypervisor limit) reads 0, and both interrupt outputs are low.
- R2: Outside hypervisor mode, with guest period P nonzero, each cycle with tickEn advances the guest count by one. When the count is already at or above P-1, a tick instead loads 0 and sets the status flag. With P = 0 the guest count does not move.
- R3: In hypervisor mode the guest count never changes on ticks. Only a write changes it.
- R4: A guest-count write outside hypervisor mode stores wrData exactly and does not touch the status flag. The write takes priority over a tick in the same cycle.
- R5: A guest-count write in hypervisor mode stores wrData plus the current hypervisor count.
- R6: If that sum is at least P (with P nonzero), the stored value is the sum minus P, and the status flag is set at the same edge.
- R7: guestIrq equals the status flag. A read with rdEn at select 2 returns the flag in bit 0 (other bits 0) and clears it at the edge. A flag set in that same cycle wins over the clear.
- R8: The hypervisor count increments on every tickEn in any mode. A hypervisor-mode write to it clears it to 0 whatever the data, and the clear wins over a same-cycle tick.
- R9: hypIrq pulses high for the cycle after a tick in which the hypervisor count plus one equals a nonzero hypervisor limit, unless the count is being cleared in that cycle.
- R10: Outside hypervisor mode, reads of select 3 and 4 return 0, and writes to them are ignored.
- R11: Select encoding: 0 is the guest period (writable in any mode), 1 is the guest count, 2 is status (read-only), 3 is the hypervisor count, and 4 is the hypervisor limit. Selects 5 to 7 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hypMode | input | 1 | Core is executing in hypervisor mode |
| tickEn | input | 1 | Prescaled count enable for both counters |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 3 | Register select for writes |
| wrData | input | W | Write data |
| rdEn | input | 1 | Read strobe (side effect: status clear) |
| rdSel | input | 3 | Register select for reads |
| rdData | output | W | Combinational read data |
| guestIrq | output | 1 | Guest timer interrupt (level, status flag) |
| hypIrq | output | 1 | Hypervisor scheduling tick, one-cycle pulse to the core |

## Verification
The bench aims at the restore path with sums just below, equal to and above the guest period. A design that compared with the wrong bound would either miss the immediate guest interrupt or wrap one tick early. It also mixes mode changes with ticks, because a design that let the guest counter run in hypervisor mode would show a drifting count on readback. Status reads that coincide with a wrap or a restore overflow are exercised, since a clear-wins priority would drop an interrupt. Guest-mode accesses to the hypervisor registers are checked to read 0 and to leave the limit and count intact.

// File: rtl/hvTimerPkg.sv
package hvTimerPkg;
  localparam logic [2:0] SEL_GPERIOD = 3'd0;
  localparam logic [2:0] SEL_GCOUNT  = 3'd1;
  localparam logic [2:0] SEL_GSTATUS = 3'd2;
  localparam logic [2:0] SEL_HCOUNT  = 3'd3;
  localparam logic [2:0] SEL_HLIMIT  = 3'd4;

  typedef struct packed {
    logic wrGPeriod;
    logic wrGCountDirect;
    logic wrGCountRestore;
    logic clrStatus;
    logic clrHCount;
    logic wrHLimit;
    logic gTick;
    logic hTick;
    logic hypVisible;
  } strobe_t;
endpackage

// File: rtl/hvTimerCtrl.sv
module hvTimerCtrl
  import hvTimerPkg::*;
(
  input  logic       hypMode,
  input  logic       tickEn,
  input  logic       wrEn,
  input  logic [2:0] wrSel,
  input  logic       rdEn,
  input  logic [2:0] rdSel,
  output strobe_t    stb
);
  logic wrGCount;

  always_comb begin
    wrGCount              = wrEn && (wrSel == SEL_GCOUNT);
    stb.wrGPeriod         = wrEn && (wrSel == SEL_GPERIOD);
    stb.wrGCountDirect    = wrGCount && !hypMode;
    stb.wrGCountRestore   = wrGCount && hypMode;
    stb.clrStatus         = rdEn && (rdSel == SEL_GSTATUS);
    stb.clrHCount         = wrEn && hypMode && (wrSel == SEL_HCOUNT);
    stb.wrHLimit          = wrEn && hypMode && (wrSel == SEL_HLIMIT);
    stb.gTick             = tickEn && !hypMode;
    stb.hTick             = tickEn;
    stb.hypVisible        = hypMode;
  end
endmodule

// File: rtl/hvTimerDp.sv
module hvTimerDp
  import hvTimerPkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  strobe_t      stb,
  input  logic [W-1:0] wrData,
  input  logic [2:0]   rdSel,
  output logic [W-1:0] rdData,
  output logic         guestIrq,
  output logic         hypIrq
);
  localparam int SW = W + 1;

  logic [W-1:0]  gPeriod, gCount, hCount, hLimit;
  logic          gStatus, hIrqQ;
  logic [SW-1:0] restoreSum, periodExt, restoreDiff;
  logic          restoreOvf, gAdvance, gWrap, gSet, hHit;
  logic [W-1:0]  hCountInc, gCountNext;

  always_comb begin
    periodExt   = {1'b0, gPeriod};
    restoreSum  = {1'b0, wrData} + {1'b0, hCount};
    restoreDiff = restoreSum - periodExt;
    restoreOvf  = (gPeriod != '0) && (restoreSum >= periodExt);
    gAdvance    = stb.gTick && (gPeriod != '0) && !stb.wrGCountDirect;
    gWrap       = gCount >= (gPeriod - W'(1));
    gSet        = (stb.wrGCountRestore && restoreOvf) || (gAdvance && gWrap);
    hCountInc   = hCount + W'(1);
    hHit        = stb.hTick && !stb.clrHCount && (hLimit != '0) && (hCountInc == hLimit);

    if (stb.wrGCountDirect)       gCountNext = wrData;
    else if (stb.wrGCountRestore) gCountNext = restoreOvf ? restoreDiff[W-1:0] : restoreSum[W-1:0];
    else if (gAdvance)            gCountNext = gWrap ? '0 : gCount + W'(1);
    else                          gCountNext = gCount;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gPeriod <= '0;
      gCount  <= '0;
      gStatus <= 1'b0;
      hCount  <= '0;
      hLimit  <= '0;
      hIrqQ   <= 1'b0;
    end else begin
      if (stb.wrGPeriod) gPeriod <= wrData;
      gCount <= gCountNext;
      if (gSet)               gStatus <= 1'b1;
      else if (stb.clrStatus) gStatus <= 1'b0;
      if (stb.clrHCount)  hCount <= '0;
      else if (stb.hTick) hCount <= hCountInc;
      if (stb.wrHLimit) hLimit <= wrData;
      hIrqQ <= hHit;
    end
  end

  always_comb begin
    unique case (rdSel)
      SEL_GPERIOD: rdData = gPeriod;
      SEL_GCOUNT:  rdData = gCount;
      SEL_GSTATUS: rdData = {{(W-1){1'b0}}, gStatus};
      SEL_HCOUNT:  rdData = stb.hypVisible ? hCount : '0;
      SEL_HLIMIT:  rdData = stb.hypVisible ? hLimit : '0;
      default:     rdData = '0;
    endcase
  end

  assign guestIrq = gStatus;
  assign hypIrq   = hIrqQ;
endmodule

// File: rtl/hvTickTimer.sv
module hvTickTimer
  import hvTimerPkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         hypMode,
  input  logic         tickEn,
  input  logic         wrEn,
  input  logic [2:0]   wrSel,
  input  logic [W-1:0] wrData,
  input  logic         rdEn,
  input  logic [2:0]   rdSel,
  output logic [W-1:0] rdData,
  output logic         guestIrq,
  output logic         hypIrq
);
  strobe_t stb;

  hvTimerCtrl u_ctrl (
    .hypMode(hypMode), .tickEn(tickEn), .wrEn(wrEn), .wrSel(wrSel),
    .rdEn(rdEn), .rdSel(rdSel), .stb(stb)
  );

  hvTimerDp #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .rdSel(rdSel),
    .rdData(rdData), .guestIrq(guestIrq), .hypIrq(hypIrq)
  );
endmodule

// File: rtl/hvTickTimer_chk.sv
module hvTickTimer_chk
  import hvTimerPkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         hypMode,
  input logic         tickEn,
  input logic         wrEn,
  input logic [2:0]   wrSel,
  input logic [2:0]   rdSel,
  input logic [W-1:0] rdData,
  input logic         guestIrq,
  input logic         hypIrq
);
  // R10: hypervisor registers hidden from guests
  p_hyp_hidden_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!hypMode && (rdSel == SEL_HCOUNT || rdSel == SEL_HLIMIT)) |-> (rdData == '0));

  // R3: guest count frozen in hypervisor mode without a write
  p_frozen_r3: assert property (@(posedge clk) disable iff (!rstN)
    (hypMode && $past(hypMode) && !$past(wrEn && wrSel == SEL_GCOUNT)
     && rdSel == SEL_GCOUNT && $past(rdSel) == SEL_GCOUNT) |-> (rdData == $past(rdData)));

  // R8: hypervisor write clears its counter
  p_hyp_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(hypMode && wrEn && wrSel == SEL_HCOUNT) && hypMode && rdSel == SEL_HCOUNT)
    |-> (rdData == '0));

  // R9: scheduling tick only follows a tick enable, and never twice from one tick
  p_hirq_after_tick_r9: assert property (@(posedge clk) disable iff (!rstN)
    hypIrq |-> $past(tickEn));

  // R2 / R6: guest interrupt rises only after a guest tick or a hypervisor restore
  p_girq_cause_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(guestIrq) |-> ($past(tickEn && !hypMode) || $past(wrEn && hypMode && wrSel == SEL_GCOUNT)));
endmodule

bind hvTickTimer hvTickTimer_chk #(.W(W)) u_chk (
  .clk(clk), .rstN(rstN), .hypMode(hypMode), .tickEn(tickEn), .wrEn(wrEn),
  .wrSel(wrSel), .rdSel(rdSel), .rdData(rdData), .guestIrq(guestIrq), .hypIrq(hypIrq)
);

// File: tb/hvTickTimer_test.sv
module hvTickTimer_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         hypMode = 1'b0, tickEn = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [2:0]   wrSel = 3'd0, rdSel = 3'd0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] rdData;
  logic         guestIrq, hypIrq;

  int vectors = 0;
  int miscompares = 0;

  // bench view of the register state, derived from the requirements
  logic [W-1:0] mGp = '0, mGc = '0, mHc = '0, mHl = '0;
  logic         mSt = 1'b0, mHi = 1'b0;

  hvTickTimer #(.W(W)) uut (
    .clk(clk), .rstN(rstN), .hypMode(hypMode), .tickEn(tickEn), .wrEn(wrEn),
    .wrSel(wrSel), .wrData(wrData), .rdEn(rdEn), .rdSel(rdSel),
    .rdData(rdData), .guestIrq(guestIrq), .hypIrq(hypIrq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [W-1:0] expRead(input logic hm, input logic [2:0] rs);
    case (rs)
      3'd0: return mGp;
      3'd1: return mGc;
      3'd2: return {{(W-1){1'b0}}, mSt};
      3'd3: return hm ? mHc : '0;
      3'd4: return hm ? mHl : '0;
      default: return '0;
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic stepModel(input logic hm, input logic te, input logic we, input logic [2:0] ws,
                           input logic [W-1:0] wd, input logic re, input logic [2:0] rs);
    logic [W:0]   sum;
    logic [W-1:0] nGc;
    logic         set, clrH;
    sum = {1'b0, wd} + {1'b0, mHc};
    nGc = mGc; set = 1'b0;
    clrH = we && hm && ws == 3'd3;
    if (we && ws == 3'd1 && !hm) nGc = wd;
    else if (we && ws == 3'd1 && hm) begin
      if (mGp != 0 && sum >= {1'b0, mGp}) begin nGc = W'(sum - {1'b0, mGp}); set = 1'b1; end
      else nGc = sum[W-1:0];
    end else if (te && !hm && mGp != 0) begin
      if (mGc >= mGp - 1) begin nGc = '0; set = 1'b1; end
      else nGc = mGc + 1;
    end
    mHi = te && !clrH && mHl != 0 && (mHc + W'(1)) == mHl;
    mGc = nGc;
    if (set) mSt = 1'b1; else if (re && rs == 3'd2) mSt = 1'b0;
    if (clrH) mHc = '0; else if (te) mHc = mHc + 1;
    if (we && hm && ws == 3'd4) mHl = wd;
    if (we && ws == 3'd0) mGp = wd;
  endtask

  task automatic doCycle(input string req, input logic hm, input logic te, input logic we,
                         input logic [2:0] ws, input logic [W-1:0] wd, input logic re,
                         input logic [2:0] rs);
    hypMode = hm; tickEn = te; wrEn = we; wrSel = ws; wrData = wd; rdEn = re; rdSel = rs;
    #1;
    check(req, rdData, expRead(hm, rs));
    @(posedge clk);
    stepModel(hm, te, we, ws, wd, re, rs);
    #2;
    check({req, " guestIrq"}, {{(W-1){1'b0}}, guestIrq}, {{(W-1){1'b0}}, mSt});
    check({req, " hypIrq"},   {{(W-1){1'b0}}, hypIrq},   {{(W-1){1'b0}}, mHi});
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    // R1: reset state of every register
    for (int s = 0; s < 5; s++) doCycle("R1 reset", 1'b1, 1'b0, 1'b0, 3'd0, '0, 1'b0, 3'(s));
    // R2: guest periodic counting with period 4, R11 select 0 period
    doCycle("R11 period wr", 1'b0, 1'b0, 1'b1, 3'd0, 16'd4, 1'b0, 3'd0);
    for (int i = 0; i < 6; i++) doCycle("R2 count", 1'b0, 1'b1, 1'b0, 3'd0, '0, 1'b0, 3'd1);
    // R7: status read clears, guestIrq tracks
    doCycle("R7 status read", 1'b0, 1'b0, 1'b0, 3'd0, '0, 1'b1, 3'd2);
    doCycle("R7 after clear", 1'b0, 1'b0, 1'b0, 3'd0, '0, 1'b0, 3'd2);
    // R3: frozen in hypervisor mode, R8 hyp count runs
    for (int i = 0; i < 5; i++) doCycle("R3 frozen", 1'b1, 1'b1, 1'b0, 3'd0, '0, 1'b0, 3'd1);
    doCycle("R8 hyp count", 1'b1, 1'b0, 1'b0, 3'd0, '0, 1'b0, 3'd3);
    // R8: clear wins over tick, data ignored
    doCycle("R8 clear", 1'b1, 1'b1, 1'b1, 3'd3, 16'h00ff, 1'b0, 3'd3);
    doCycle("R8 cleared", 1'b1, 1'b0, 1'b0, 3'd0, '0, 1'b0, 3'd3);
    // R5: restore below period (hyp count 1, data 1 -> 2)
    doCycle("R5 tick", 1'b1, 1'b1, 1'b0, 3'd0, '0, 1'b0, 3'd3);
    doCycle("R5 restore", 1'b1, 1'b0, 1'b1, 3'd1, 16'd1, 1'b0, 3'd1);
    doCycle("R5 readback", 1'b1, 1'b0, 1'b0, 3'd0, '0, 1'b0, 3'd1);
    // R6: restore at and above the period
    doCycle("R6 restore eq", 1'b1, 1'b0, 1'b1, 3'd1, 16'd3, 1'b0, 3'd1);
    doCycle("R6 readback eq", 1'b1, 1'b0, 1'b0, 3'd0, '0, 1'b1, 3'd2);
    doCycle("R6 restore over", 1'b1, 1'b0, 1'b1, 3'd1, 16'd5, 1'b0, 3'd1);
    // R7: set wins over same-cycle clear
    doCycle("R7 set wins", 1'b1, 1'b0, 1'b1, 3'd1, 16'd6, 1'b1, 3'd2);
    // R4: direct guest write wins over tick, no status change
    doCycle("R4 clr", 1'b0, 1'b0, 1'b0, 3'd0, '0, 1'b1, 3'd2);
    doCycle("R4 direct", 1'b0, 1'b1, 1'b1, 3'd1, 16'd3, 1'b0, 3'd1);
    doCycle("R4 readback", 1'b0, 1'b0, 1'b0, 3'd0, '0, 1'b0, 3'd1);
    // R10: guest writes to hyp registers ignored, reads 0
    doCycle("R10 wr limit", 1'b0, 1'b0, 1'b1, 3'd4, 16'd9, 1'b0, 3'd4);
    doCycle("R10 wr count", 1'b0, 1'b0, 1'b1, 3'd3, 16'd9, 1'b0, 3'd3);
    doCycle("R10 hyp view", 1'b1, 1'b0, 1'b0, 3'd0, '0, 1'b0, 3'd4);
    // R11: unused selects
    doCycle("R11 sel7 wr", 1'b1, 1'b0, 1'b1, 3'd7, 16'd9, 1'b0, 3'd7);
    // R9: hyp tick pulse with limit 3
    doCycle("R9 limit", 1'b1, 1'b0, 1'b1, 3'd4, 16'd3, 1'b0, 3'd4);
    doCycle("R9 clear", 1'b1, 1'b0, 1'b1, 3'd3, '0, 1'b0, 3'd3);
    for (int i = 0; i < 5; i++) doCycle("R9 pulse", 1'b0, 1'b1, 1'b0, 3'd0, '0, 1'b0, 3'd1);
    // R2: period 0 halts guest count
    doCycle("R2 period0", 1'b0, 1'b0, 1'b1, 3'd0, 16'd0, 1'b0, 3'd0);
    for (int i = 0; i < 3; i++) doCycle("R2 halted", 1'b0, 1'b1, 1'b0, 3'd0, '0, 1'b0, 3'd1);
    // random mix over all requirements
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] ws, rs;
      logic [W-1:0] wd;
      ws = 3'($urandom_range(0, 5));
      rs = 3'($urandom_range(0, 5));
      wd = W'($urandom_range(0, 14));
      doCycle("R2-mix random", 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              ($urandom_range(0, 3) == 0), ws, wd, ($urandom_range(0, 2) == 0), rs);
    end
    finishRun();
  end
endmodule